// File: doc/BRIEF.md
# Program Memory Table Access Unit

This unit moves single bytes between a byte-addressed program memory and the data side of a processor. It holds a 22-bit table pointer and an 8-bit table latch. The data side writes the pointer as three byte registers and writes the latch directly. A table-read command fetches the byte at the pointer address into the latch through a synchronous memory read port. A table-write command copies the latch byte into one slot of a 64-entry holding buffer. The flash programmer later drains that buffer.

Every command carries a pointer-update mode. The pointer can stay put, step up after the access, step down after the access, or step up before the access. A step changes only the low 21 bits. Bit 21 keeps its value, because that bit chooses between the main memory space and the ID/configuration space. Commit and erase requests produce a one-cycle strobe carrying the 1024-byte block number held in pointer bits 21:10.

A small state machine controls the unit. It has three states:
- `ST_IDLE`: the unit accepts commands, commit requests and erase requests.
- `ST_ISSUE`: the memory read request is driven for one cycle.
- `ST_WAIT`: the unit waits for read data.

It has four transitions:
- `ST_IDLE`→`ST_ISSUE` on a read command.
- `ST_ISSUE`→`ST_WAIT` always.
- `ST_WAIT`→`ST_IDLE` on read-data valid.
- `ST_IDLE`→`ST_IDLE` on a write command, a commit or an erase.

Top module: `tblacc_unit`

## Requirements
- R1: The pointer is built from three byte registers, selected by `reg_wr_sel`: 0 = bits 7:0, 1 = bits 15:8, 2 = bits 21:16. For selector 2, only data bits 5:0 are used. A byte write takes effect at the next clock edge. `ptr_q` shows the whole pointer, and it resets to zero.
- R2: Selector 3 writes the 8-bit latch. The latch resets to zero and changes only on a latch write or on a completed read.
- R3: `cmd_mode` encodes the update mode: 0 = none, 1 = increment after, 2 = decrement after, 3 = increment before. Mode 3 accesses the incremented address. The other modes access the old address.
- R4: Increment and decrement act on bits 20:0 and wrap within them. Bit 21 is never changed by a command.
- R5: A read command (`cmd_write`=0) accepted in idle raises `mem_rd_req` for exactly one cycle, starting one cycle after acceptance, with the full 22-bit address. `busy` is high from the cycle after acceptance until the read data is captured into the latch. For post modes, the pointer updates at that same capture edge.
- R6: Commands that arrive while `busy` is high are ignored. They change neither the pointer nor the holding buffer.
- R7: A write command (`cmd_write`=1) completes at its accepting edge without raising `busy`. It stores the latch into the holding slot given by access-address bits 5:0 and updates the pointer at that same edge.
- R8: A commit or erase request is accepted only in idle with no command present. The matching strobe is high one cycle later, for one cycle, with `blk_addr` equal to pointer bits 21:10. Commit wins over erase.
- R9: Every holding slot reads 0xFF after reset and after an accepted commit request. An erase leaves the buffer untouched.
- R10: If a byte-register write lands in the same cycle as a command's pointer update, the written byte overrides that byte of the updated pointer. The other bytes still take the update.
- R11: `hold_rd_data` shows holding slot `hold_rd_idx` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr_en | input | 1 | Data-side byte register write |
| reg_wr_sel | input | 2 | Register selector (0 low, 1 high, 2 upper, 3 latch) |
| reg_wr_data | input | 8 | Byte written |
| ptr_q | output | 22 | Current table pointer |
| latch_q | output | 8 | Current table latch |
| cmd_valid | input | 1 | Command present |
| cmd_write | input | 1 | 1 = table write, 0 = table read |
| cmd_mode | input | 2 | Pointer-update mode |
| busy | output | 1 | Read in progress |
| mem_rd_req | output | 1 | Program memory read request |
| mem_rd_addr | output | 22 | Read byte address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 8 | Read data |
| commit_req | input | 1 | Request to commit holding buffer |
| erase_req | input | 1 | Request to erase a block |
| blk_commit | output | 1 | Commit strobe |
| blk_erase | output | 1 | Erase strobe |
| blk_addr | output | 12 | Target 1024-byte block number |
| hold_rd_idx | input | 6 | Holding buffer read index |
| hold_rd_data | output | 8 | Holding buffer read data |

## Verification
The bench drives the pointer across the bit-20 boundary in both directions, with bit 21 clear and with bit 21 set.
- A design that let the carry or borrow reach bit 21 would jump between memory spaces.
- A design that forgot to wrap would leave stray high bits.

The pre-increment cases check the address on the memory port and the holding-slot index.
- A design that accessed before stepping would hit the neighbouring byte.

A write command sent during a read, and a byte write colliding with an increment, target two failure modes.
- A design that did not ignore the busy command would corrupt the pointer or a holding slot.
- A design with the wrong priority would lose either the written byte or the carry into the next byte.

// File: rtl/tblacc_pkg.sv
package tblacc_pkg;

    typedef enum logic [1:0] {
        PM_NONE     = 2'd0,
        PM_POST_INC = 2'd1,
        PM_POST_DEC = 2'd2,
        PM_PRE_INC  = 2'd3
    } ptr_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } fsm_state_e;

    typedef enum logic [1:0] {
        SEL_LOW   = 2'd0,
        SEL_HIGH  = 2'd1,
        SEL_UPPER = 2'd2,
        SEL_LATCH = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/tblacc_ptr.sv
module tblacc_ptr #(
    parameter int PTR_W  = 22,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_we,
    input  logic [1:0]        byte_sel,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              upd_en,
    input  logic              upd_dec,
    output logic [PTR_W-1:0]  ptr,
    output logic [PTR_W-1:0]  ptr_inc
);
    localparam int UPD_W = PTR_W - 1;

    logic [PTR_W-1:0] ptr_dec;
    logic [PTR_W-1:0] ptr_nxt;

    // Step only the low UPD_W bits; the space-select bit is carried over.
    assign ptr_inc = {ptr[PTR_W-1], ptr[UPD_W-1:0] + {{(UPD_W-1){1'b0}}, 1'b1}};
    assign ptr_dec = {ptr[PTR_W-1], ptr[UPD_W-1:0] - {{(UPD_W-1){1'b0}}, 1'b1}};

    always_comb begin
        ptr_nxt = ptr;
        if (upd_en) begin
            ptr_nxt = upd_dec ? ptr_dec : ptr_inc;
        end
        // A data-side byte write overrides the updated value of its byte.
        for (int b = 0; b < PTR_W; b++) begin
            if (byte_we && (32'(byte_sel) == b / DATA_W)) begin
                ptr_nxt[b] = byte_data[b % DATA_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else begin
            ptr <= ptr_nxt;
        end
    end
endmodule

// File: rtl/tblacc_hold.sv
module tblacc_hold #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IW-1:0]     widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              clr,
    input  logic [IW-1:0]     ridx,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] slot [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    slot[i] <= '1;
                end else if (clr) begin
                    slot[i] <= '1;
                end else if (we && (widx == IW'(i))) begin
                    slot[i] <= wdata;
                end
            end
        end
    endgenerate

    assign rdata = slot[ridx];
endmodule

// File: rtl/tblacc_fsm.sv
module tblacc_fsm
    import tblacc_pkg::*;
#(
    parameter int PTR_W   = 22,
    parameter int DATA_W  = 8,
    parameter int HOLD_IW = 6,
    parameter int BLK_LSB = 10,
    localparam int BLK_W  = PTR_W - BLK_LSB
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic               cmd_write,
    input  logic [1:0]         cmd_mode,
    input  logic               commit_req,
    input  logic               erase_req,
    input  logic               mem_rd_valid,
    input  logic [DATA_W-1:0]  mem_rd_data,
    input  logic               latch_we,
    input  logic [DATA_W-1:0]  latch_wdata,
    input  logic [PTR_W-1:0]   ptr,
    input  logic [PTR_W-1:0]   ptr_inc,
    output logic               busy,
    output logic               mem_rd_req,
    output logic [PTR_W-1:0]   mem_rd_addr,
    output logic [DATA_W-1:0]  latch,
    output logic               upd_en,
    output logic               upd_dec,
    output logic               hold_we,
    output logic [HOLD_IW-1:0] hold_widx,
    output logic [DATA_W-1:0]  hold_wdata,
    output logic               hold_clr,
    output logic               blk_commit,
    output logic               blk_erase,
    output logic [BLK_W-1:0]   blk_addr
);
    fsm_state_e       state_q, state_d;
    ptr_mode_e        mode_in, mode_q;
    logic [PTR_W-1:0] addr_q;
    logic [PTR_W-1:0] acc_addr;
    logic             accept, rd_accept, rd_done, take_commit, take_erase;

    assign mode_in     = ptr_mode_e'(cmd_mode);
    assign accept      = (state_q == ST_IDLE) && cmd_valid;
    assign rd_accept   = accept && !cmd_write;
    assign rd_done     = (state_q == ST_WAIT) && mem_rd_valid;
    assign take_commit = (state_q == ST_IDLE) && !cmd_valid && commit_req;
    assign take_erase  = (state_q == ST_IDLE) && !cmd_valid && !commit_req && erase_req;
    assign acc_addr    = (mode_in == PM_PRE_INC) ? ptr_inc : ptr;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (rd_accept) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  if (mem_rd_valid) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register and captured read context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= PM_NONE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (rd_accept) begin
                mode_q <= mode_in;
                addr_q <= acc_addr;
            end
        end
    end

    // Latch and block strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch      <= '0;
            blk_commit <= 1'b0;
            blk_erase  <= 1'b0;
            blk_addr   <= '0;
        end else begin
            if (latch_we) begin
                latch <= latch_wdata;
            end else if (rd_done) begin
                latch <= mem_rd_data;
            end
            blk_commit <= take_commit;
            blk_erase  <= take_erase;
            if (take_commit || take_erase) begin
                blk_addr <= ptr[PTR_W-1:BLK_LSB];
            end
        end
    end

    // Outputs per state
    always_comb begin
        busy        = 1'b0;
        mem_rd_req  = 1'b0;
        mem_rd_addr = addr_q;
        upd_en      = 1'b0;
        upd_dec     = 1'b0;
        hold_we     = 1'b0;
        hold_widx   = acc_addr[HOLD_IW-1:0];
        hold_wdata  = latch;
        hold_clr    = take_commit;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    hold_we = cmd_write;
                    upd_dec = (mode_in == PM_POST_DEC);
                    upd_en  = (mode_in == PM_PRE_INC) ||
                              (cmd_write && (mode_in != PM_NONE));
                end
            end
            ST_ISSUE: begin
                busy       = 1'b1;
                mem_rd_req = 1'b1;
            end
            ST_WAIT: begin
                busy = 1'b1;
                if (mem_rd_valid) begin
                    upd_en  = (mode_q == PM_POST_INC) || (mode_q == PM_POST_DEC);
                    upd_dec = (mode_q == PM_POST_DEC);
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/tblacc_unit.sv
module tblacc_unit
    import tblacc_pkg::*;
#(
    parameter int PTR_W      = 22,
    parameter int DATA_W     = 8,
    parameter int HOLD_DEPTH = 64,
    parameter int BLK_LSB    = 10,
    localparam int HOLD_IW   = $clog2(HOLD_DEPTH),
    localparam int BLK_W     = PTR_W - BLK_LSB
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic [1:0]         reg_wr_sel,
    input  logic [DATA_W-1:0]  reg_wr_data,
    output logic [PTR_W-1:0]   ptr_q,
    output logic [DATA_W-1:0]  latch_q,
    input  logic               cmd_valid,
    input  logic               cmd_write,
    input  logic [1:0]         cmd_mode,
    output logic               busy,
    output logic               mem_rd_req,
    output logic [PTR_W-1:0]   mem_rd_addr,
    input  logic               mem_rd_valid,
    input  logic [DATA_W-1:0]  mem_rd_data,
    input  logic               commit_req,
    input  logic               erase_req,
    output logic               blk_commit,
    output logic               blk_erase,
    output logic [BLK_W-1:0]   blk_addr,
    input  logic [HOLD_IW-1:0] hold_rd_idx,
    output logic [DATA_W-1:0]  hold_rd_data
);
    logic [PTR_W-1:0]   ptr_inc;
    logic               upd_en, upd_dec, hold_we, hold_clr;
    logic [HOLD_IW-1:0] hold_widx;
    logic [DATA_W-1:0]  hold_wdata;
    logic               ptr_byte_we, latch_we;

    assign ptr_byte_we = reg_wr_en && (reg_sel_e'(reg_wr_sel) != SEL_LATCH);
    assign latch_we    = reg_wr_en && (reg_sel_e'(reg_wr_sel) == SEL_LATCH);

    tblacc_ptr #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_we  (ptr_byte_we),
        .byte_sel (reg_wr_sel),
        .byte_data(reg_wr_data),
        .upd_en   (upd_en),
        .upd_dec  (upd_dec),
        .ptr      (ptr_q),
        .ptr_inc  (ptr_inc)
    );

    tblacc_fsm #(
        .PTR_W(PTR_W), .DATA_W(DATA_W), .HOLD_IW(HOLD_IW), .BLK_LSB(BLK_LSB)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_write   (cmd_write),
        .cmd_mode    (cmd_mode),
        .commit_req  (commit_req),
        .erase_req   (erase_req),
        .mem_rd_valid(mem_rd_valid),
        .mem_rd_data (mem_rd_data),
        .latch_we    (latch_we),
        .latch_wdata (reg_wr_data),
        .ptr         (ptr_q),
        .ptr_inc     (ptr_inc),
        .busy        (busy),
        .mem_rd_req  (mem_rd_req),
        .mem_rd_addr (mem_rd_addr),
        .latch       (latch_q),
        .upd_en      (upd_en),
        .upd_dec     (upd_dec),
        .hold_we     (hold_we),
        .hold_widx   (hold_widx),
        .hold_wdata  (hold_wdata),
        .hold_clr    (hold_clr),
        .blk_commit  (blk_commit),
        .blk_erase   (blk_erase),
        .blk_addr    (blk_addr)
    );

    tblacc_hold #(.DEPTH(HOLD_DEPTH), .DATA_W(DATA_W)) u_hold (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (hold_we),
        .widx (hold_widx),
        .wdata(hold_wdata),
        .clr  (hold_clr),
        .ridx (hold_rd_idx),
        .rdata(hold_rd_data)
    );
endmodule

// File: rtl/tblacc_unit_chk.sv
module tblacc_unit_chk #(
    parameter int PTR_W  = 22,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              mem_rd_req,
    input logic              mem_rd_valid,
    input logic              reg_wr_en,
    input logic [1:0]        reg_wr_sel,
    input logic [PTR_W-1:0]  ptr_q,
    input logic [DATA_W-1:0] latch_q,
    input logic              blk_commit,
    input logic              blk_erase
);
    AST_RDREQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req); // R5

    AST_RDREQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> busy); // R5

    AST_SPACE_BIT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr_en |=> ptr_q[PTR_W-1] == $past(ptr_q[PTR_W-1])); // R4

    AST_BUSY_PTR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_rd_valid && !reg_wr_en) |=> $stable(ptr_q)); // R6

    AST_LATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_valid && !(reg_wr_en && reg_wr_sel == 2'd3)) |=> $stable(latch_q)); // R2

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(blk_commit && blk_erase)); // R8

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_commit || blk_erase) |=> !(blk_commit || blk_erase)); // R8
endmodule

bind tblacc_unit tblacc_unit_chk #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .mem_rd_req  (mem_rd_req),
    .mem_rd_valid(mem_rd_valid),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_sel  (reg_wr_sel),
    .ptr_q       (ptr_q),
    .latch_q     (latch_q),
    .blk_commit  (blk_commit),
    .blk_erase   (blk_erase)
);

// File: tb/tblacc_unit_bench.sv
module tblacc_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_wr_sel = 2'd0;
    logic [7:0]  reg_wr_data = 8'd0;
    logic [21:0] ptr_q;
    logic [7:0]  latch_q;
    logic        cmd_valid = 1'b0;
    logic        cmd_write = 1'b0;
    logic [1:0]  cmd_mode = 2'd0;
    logic        busy;
    logic        mem_rd_req;
    logic [21:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [7:0]  mem_rd_data = 8'd0;
    logic        commit_req = 1'b0;
    logic        erase_req = 1'b0;
    logic        blk_commit, blk_erase;
    logic [11:0] blk_addr;
    logic [5:0]  hold_rd_idx = 6'd0;
    logic [7:0]  hold_rd_data;

    int checks = 0;
    int failures = 0;
    logic [21:0] exp_addr_q[$];
    logic        pend = 1'b0;
    logic [7:0]  pend_data = 8'd0;
    logic        finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tblacc_unit u_tblacc_unit (.*);

    function automatic logic [7:0] mem_fn(input logic [21:0] a);
        return a[7:0] ^ a[15:8] ^ {2'b00, a[21:16]} ^ 8'h5A;
    endfunction

    function automatic logic [21:0] step(input logic [21:0] p, input bit dec);
        logic [20:0] lo;
        lo = dec ? p[20:0] - 21'd1 : p[20:0] + 21'd1;
        return {p[21], lo};
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    // Memory model: one-cycle latency from request to valid.
    always @(negedge clk) begin
        mem_rd_valid <= pend;
        mem_rd_data  <= pend_data;
        pend         <= mem_rd_req;
        pend_data    <= mem_fn(mem_rd_addr);
    end

    // Monitor: compare each memory request against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && mem_rd_req) begin
            if (exp_addr_q.size() == 0) begin
                check("R5 unexpected request", 32'(mem_rd_addr), 32'hFFFFFFFF);
            end else begin
                check("R3 R5 read address", 32'(mem_rd_addr), 32'(exp_addr_q.pop_front()));
            end
        end
    end

    task automatic set_reg(input logic [1:0] sel, input logic [7:0] d);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic set_ptr(input logic [21:0] p);
        set_reg(2'd0, p[7:0]);
        set_reg(2'd1, p[15:8]);
        set_reg(2'd2, {2'b00, p[21:16]});
    endtask

    task automatic do_read(input logic [1:0] mode, input string req);
        logic [21:0] p0, a, pe;
        p0 = ptr_q;
        a  = (mode == 2'd3) ? step(p0, 1'b0) : p0;
        pe = (mode == 2'd0) ? p0 : (mode == 2'd2) ? step(p0, 1'b1) : step(p0, 1'b0);
        exp_addr_q.push_back(a);
        cmd_valid = 1'b1; cmd_write = 1'b0; cmd_mode = mode;
        @(negedge clk);
        cmd_valid = 1'b0;
        check({req, " busy after accept"}, 32'(busy), 32'd1);
        for (int i = 0; i < 20 && busy; i++) @(negedge clk);
        check({req, " latch"}, 32'(latch_q), 32'(mem_fn(a)));
        check({req, " pointer"}, 32'(ptr_q), 32'(pe));
    endtask

    task automatic do_write(input logic [1:0] mode, input string req);
        logic [21:0] p0, a, pe;
        logic [7:0]  l;
        p0 = ptr_q; l = latch_q;
        a  = (mode == 2'd3) ? step(p0, 1'b0) : p0;
        pe = (mode == 2'd0) ? p0 : (mode == 2'd2) ? step(p0, 1'b1) : step(p0, 1'b0);
        cmd_valid = 1'b1; cmd_write = 1'b1; cmd_mode = mode;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_write = 1'b0;
        check({req, " no busy"}, 32'(busy), 32'd0);
        check({req, " pointer"}, 32'(ptr_q), 32'(pe));
        hold_rd_idx = a[5:0]; #1;
        check({req, " slot"}, 32'(hold_rd_data), 32'(l));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        check("R1 reset pointer", 32'(ptr_q), 32'd0);
        check("R2 reset latch", 32'(latch_q), 32'd0);
        check("R5 reset busy", 32'(busy), 32'd0);
        hold_rd_idx = 6'd0; #1; check("R9 reset slot 0", 32'(hold_rd_data), 32'hFF);
        hold_rd_idx = 6'd63; #1; check("R11 reset slot 63", 32'(hold_rd_data), 32'hFF);

        // R1: byte registers; upper keeps 6 bits
        set_ptr(22'h123456);
        set_reg(2'd2, 8'hD2);
        check("R1 byte assembly", 32'(ptr_q), 32'h123456);
        set_reg(2'd3, 8'h3C);
        check("R2 latch write", 32'(latch_q), 32'h3C);

        // R3/R5 reads in each mode
        do_read(2'd0, "R3 read none");
        do_read(2'd1, "R3 read postinc");
        do_read(2'd2, "R3 read postdec");
        do_read(2'd3, "R3 read preinc");

        // R4 wrap within bits 20:0
        set_ptr(22'h1FFFFF); do_read(2'd1, "R4 wrap up low space");
        set_ptr(22'h3FFFFF); do_read(2'd3, "R4 wrap up id space");
        set_ptr(22'h200000); do_read(2'd2, "R4 wrap down id space");
        set_ptr(22'h000000); do_read(2'd2, "R4 wrap down low space");

        // R7 writes
        set_reg(2'd3, 8'hA5); set_ptr(22'h000045); do_write(2'd1, "R7 write postinc");
        set_reg(2'd3, 8'h11); set_ptr(22'h00007F); do_write(2'd3, "R7 write preinc");
        set_reg(2'd3, 8'h22); set_ptr(22'h000010); do_write(2'd2, "R7 write postdec");

        // R6: write command during a read is ignored
        set_ptr(22'h000033);
        set_reg(2'd3, 8'h77);
        exp_addr_q.push_back(22'h000033);
        cmd_valid = 1'b1; cmd_write = 1'b0; cmd_mode = 2'd0;
        @(negedge clk);
        cmd_write = 1'b1; cmd_mode = 2'd1;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_write = 1'b0;
        for (int i = 0; i < 20 && busy; i++) @(negedge clk);
        check("R6 pointer untouched", 32'(ptr_q), 32'h000033);
        hold_rd_idx = 6'h33; #1;
        check("R6 slot untouched", 32'(hold_rd_data), 32'hFF);

        // R10: byte write collides with increment
        set_ptr(22'h0000FF);
        set_reg(2'd3, 8'h99);
        cmd_valid = 1'b1; cmd_write = 1'b1; cmd_mode = 2'd1;
        reg_wr_en = 1'b1; reg_wr_sel = 2'd0; reg_wr_data = 8'h10;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_write = 1'b0; reg_wr_en = 1'b0;
        check("R10 byte write priority", 32'(ptr_q), 32'h000110);
        hold_rd_idx = 6'h3F; #1;
        check("R10 R7 slot written", 32'(hold_rd_data), 32'h99);

        // R8/R9 erase keeps buffer
        set_ptr(22'h2ABCDE);
        erase_req = 1'b1;
        @(negedge clk);
        erase_req = 1'b0;
        check("R8 erase strobe", 32'(blk_erase), 32'd1);
        check("R8 erase block", 32'(blk_addr), 32'(22'h2ABCDE >> 10));
        hold_rd_idx = 6'h05; #1;
        check("R9 erase keeps slot", 32'(hold_rd_data), 32'hA5);
        @(negedge clk);
        check("R8 erase one cycle", 32'(blk_erase), 32'd0);

        // R8/R9 commit beats erase, clears buffer
        set_ptr(22'h155400);
        commit_req = 1'b1; erase_req = 1'b1;
        @(negedge clk);
        commit_req = 1'b0; erase_req = 1'b0;
        check("R8 commit strobe", 32'(blk_commit), 32'd1);
        check("R8 commit wins", 32'(blk_erase), 32'd0);
        check("R8 commit block", 32'(blk_addr), 32'(22'h155400 >> 10));
        hold_rd_idx = 6'h05; #1;
        check("R9 commit clears", 32'(hold_rd_data), 32'hFF);

        // R8: commit ignored when a command is present
        set_reg(2'd3, 8'h44);
        commit_req = 1'b1; cmd_valid = 1'b1; cmd_write = 1'b1; cmd_mode = 2'd0;
        @(negedge clk);
        commit_req = 1'b0; cmd_valid = 1'b0; cmd_write = 1'b0;
        check("R8 commit blocked", 32'(blk_commit), 32'd0);
        hold_rd_idx = 6'h00; #1;
        check("R9 slot kept", 32'(hold_rd_data), 32'h44);

        check("R5 scoreboard drained", 32'(exp_addr_q.size()), 32'd0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule